// File: doc/BRIEF.md
# Hyperframe Control Byte Table

This block sits beside the framer of a serial link that carries one control word per basic frame, with 256 basic frames to a hyperframe. On the receive side it keeps, for every basic-frame index, the control byte most recently seen at that index. It only records a byte while the framer reports that hyperframe lock has been reached, so bytes seen while lock is being acquired or has been lost never overwrite the table. It also counts line-code violations flagged by the receiver, stopping at the top of the counter range.

On the transmit side, control bytes travel through a one-stage valid/ready pipe together with their basic-frame index. Software can arm any index with a replacement byte; an armed index has its outgoing byte swapped for the programmed one, and other indices pass through untouched. The transmit stream follows the usual rules: a byte moves when valid and ready are both high in the same cycle, and while the output is stalled its byte and valid are held. The receive stream never stalls. All table access by software goes through an index register and a small register port with one cycle of read latency.

Top module: `ctl_word_table`

## Requirements
- R1: When `rx_valid` is high and `rx_sync` equals 3'd4 (hyperframe locked), `rx_byte` is stored at entry `rx_idx` of the receive table.
- R2: With `rx_valid` low or `rx_sync` not 3'd4, the receive table is unchanged; stored entries stay as they were after lock is lost.
- R3: A register read (`reg_rd` high) gives `reg_rvalid` high with the data on `reg_rdata` in the next cycle; `reg_rvalid` is low in every cycle that does not follow a read. A read in the same cycle as a write returns the value from before that write.
- R4: Register selects on `reg_addr`: 0 is the 8-bit index register (read/write); 1 returns the receive entry at the index (read only); 2 is the transmit byte at the index (read/write); 3 is the transmit enable at the index in bit 0 (read/write, other bits read 0); 4 is the violation count (a write clears it); every other select reads 0 and writes do nothing.
- R5: A transmit byte accepted with enable set at its index leaves as the programmed byte; with enable clear it leaves unchanged.
- R6: When a register write to the transmit byte or enable of an index happens in the same cycle that a byte of that index is accepted, the accepted byte uses the contents from before the write; the new value applies from the next accepted byte of that index.
- R7: `tx_in_ready` is high whenever the output holds no byte or `tx_out_ready` is high; while `tx_out_valid` is high and `tx_out_ready` is low, the output byte and valid are held.
- R8: Each cycle with `rx_valid` and `rx_lcv` high raises the violation count by one until it reaches 255, where it stays; a clear takes priority over a count in the same cycle.
- R9: After reset all receive entries, transmit bytes and enables, the index and the count are zero, and `tx_out_valid` and `reg_rvalid` are low.
- R10: `rx_ready` is high in every cycle out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Receive control byte present |
| rx_ready | output | 1 | Receive side can take a byte |
| rx_idx | input | 8 | Basic-frame index of the received byte |
| rx_byte | input | 8 | Received control byte |
| rx_sync | input | 3 | Framer synchronization state, 3'd4 = hyperframe locked |
| rx_lcv | input | 1 | Line-code violation flag for this byte |
| tx_in_valid | input | 1 | Outgoing control byte present |
| tx_in_ready | output | 1 | Transmit pipe can take a byte |
| tx_in_idx | input | 8 | Basic-frame index of the outgoing byte |
| tx_in_byte | input | 8 | Outgoing control byte from upstream |
| tx_out_valid | output | 1 | Output byte present |
| tx_out_ready | input | 1 | Downstream takes the output byte |
| tx_out_byte | output | 8 | Control byte after substitution |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| reg_rvalid | output | 1 | Read data valid |

## Verification
A receive entry that was written outside lock, or lost, only shows when software points the index at it and reads select 1, one cycle later; the bench therefore reads back every index it touched, both after lock and after lock was dropped. A corrupted transmit byte or enable shows on `tx_out_byte` in the cycle after the next acceptance of that index, so the bench streams every armed index and its neighbours, under back-pressure as well. A counter that wraps instead of holding shows only on a read of select 4 after more than 255 violations, which the bench provokes.

// File: rtl/ctlw_pkg.sv
package ctlw_pkg;
  localparam int unsigned SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_INDEX   = 3'd0;
  localparam logic [SEL_W-1:0] SEL_RX_BYTE = 3'd1;
  localparam logic [SEL_W-1:0] SEL_TX_BYTE = 3'd2;
  localparam logic [SEL_W-1:0] SEL_TX_EN   = 3'd3;
  localparam logic [SEL_W-1:0] SEL_LCV     = 3'd4;
  localparam int unsigned SYNC_W = 3;
  localparam logic [SYNC_W-1:0] SYNC_HF_LOCK = 3'd4;
endpackage

// File: rtl/ctlw_rx_store.sv
module ctlw_rx_store
  import ctlw_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [SYNC_W-1:0] wr_sync,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0] rd_byte
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [BYTE_W-1:0] entry_q [DEPTH];
  logic              store_en;

  assign store_en = wr_valid && (wr_sync == SYNC_HF_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) entry_q[i] <= '0;
    end else if (store_en) begin
      entry_q[wr_idx] <= wr_byte;
    end
  end

  assign rd_byte = entry_q[rd_idx];
endmodule

// File: rtl/ctlw_tx_insert.sv
module ctlw_tx_insert #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_we,
  input  logic              en_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [BYTE_W-1:0] cfg_data,
  output logic [BYTE_W-1:0] cfg_byte,
  output logic              cfg_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_byte
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [BYTE_W-1:0] sub_q [DEPTH];
  logic [DEPTH-1:0]  arm_q;
  logic              accept;
  logic [BYTE_W-1:0] next_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) sub_q[i] <= '0;
      arm_q <= '0;
    end else begin
      if (byte_we) sub_q[cfg_idx] <= cfg_data;
      if (en_we)   arm_q[cfg_idx] <= cfg_data[0];
    end
  end

  assign cfg_byte  = sub_q[cfg_idx];
  assign cfg_en    = arm_q[cfg_idx];

  assign in_ready  = !out_valid || out_ready;
  assign accept    = in_valid && in_ready;
  assign next_byte = arm_q[in_idx] ? sub_q[in_idx] : in_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_byte  <= next_byte;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ctlw_reg_if.sv
module ctlw_reg_if
  import ctlw_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [SEL_W-1:0]  reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  output logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] rx_entry,
  input  logic [BYTE_W-1:0] tx_entry,
  input  logic              tx_arm,
  output logic              tx_byte_we,
  output logic              tx_en_we,
  input  logic              lcv_hit,
  output logic [CNT_W-1:0]  lcv_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic              cnt_clear;
  logic [BYTE_W-1:0] rd_mux;

  assign tx_byte_we = reg_wr && (reg_addr == SEL_TX_BYTE);
  assign tx_en_we   = reg_wr && (reg_addr == SEL_TX_EN);
  assign cnt_clear  = reg_wr && (reg_addr == SEL_LCV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else if (reg_wr && (reg_addr == SEL_INDEX)) idx <= reg_wdata[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lcv_cnt <= '0;
    else if (cnt_clear) lcv_cnt <= '0;
    else if (lcv_hit && (lcv_cnt != CNT_MAX)) lcv_cnt <= lcv_cnt + 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      SEL_INDEX:   rd_mux[IDX_W-1:0] = idx;
      SEL_RX_BYTE: rd_mux = rx_entry;
      SEL_TX_BYTE: rd_mux = tx_entry;
      SEL_TX_EN:   rd_mux[0] = tx_arm;
      SEL_LCV:     rd_mux[CNT_W-1:0] = lcv_cnt;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/ctl_word_table.sv
module ctl_word_table
  import ctlw_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [IDX_W-1:0]  rx_idx,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [SYNC_W-1:0] rx_sync,
  input  logic              rx_lcv,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [IDX_W-1:0]  tx_in_idx,
  input  logic [BYTE_W-1:0] tx_in_byte,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [BYTE_W-1:0] tx_out_byte,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [SEL_W-1:0]  reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              reg_rvalid
);
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] rx_entry;
  logic [BYTE_W-1:0] tx_entry;
  logic              tx_arm;
  logic              tx_byte_we;
  logic              tx_en_we;
  logic [CNT_W-1:0]  lcv_cnt;

  assign rx_ready = 1'b1;

  ctlw_rx_store #(.IDX_W(IDX_W), .BYTE_W(BYTE_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (rx_valid),
    .wr_sync  (rx_sync),
    .wr_idx   (rx_idx),
    .wr_byte  (rx_byte),
    .rd_idx   (idx),
    .rd_byte  (rx_entry)
  );

  ctlw_tx_insert #(.IDX_W(IDX_W), .BYTE_W(BYTE_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_we   (tx_byte_we),
    .en_we     (tx_en_we),
    .cfg_idx   (idx),
    .cfg_data  (reg_wdata),
    .cfg_byte  (tx_entry),
    .cfg_en    (tx_arm),
    .in_valid  (tx_in_valid),
    .in_ready  (tx_in_ready),
    .in_idx    (tx_in_idx),
    .in_byte   (tx_in_byte),
    .out_valid (tx_out_valid),
    .out_ready (tx_out_ready),
    .out_byte  (tx_out_byte)
  );

  ctlw_reg_if #(.IDX_W(IDX_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid),
    .idx        (idx),
    .rx_entry   (rx_entry),
    .tx_entry   (tx_entry),
    .tx_arm     (tx_arm),
    .tx_byte_we (tx_byte_we),
    .tx_en_we   (tx_en_we),
    .lcv_hit    (rx_valid && rx_lcv),
    .lcv_cnt    (lcv_cnt)
  );
endmodule

// File: rtl/ctlw_checks.sv
module ctlw_checks
  import ctlw_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [SEL_W-1:0]  reg_addr,
  input logic              reg_rvalid,
  input logic              tx_in_ready,
  input logic              tx_out_valid,
  input logic              tx_out_ready,
  input logic [BYTE_W-1:0] tx_out_byte,
  input logic [CNT_W-1:0]  lcv_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid); // R3

  AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid); // R3

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && !tx_out_ready) |=> (tx_out_valid && $stable(tx_out_byte))); // R7

  AST_EMPTY_IS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_out_valid |-> tx_in_ready); // R7

  AST_COUNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((lcv_cnt == CNT_MAX) && !(reg_wr && (reg_addr == SEL_LCV))) |=> (lcv_cnt == CNT_MAX)); // R8
endmodule

bind ctl_word_table ctlw_checks #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_rd       (reg_rd),
  .reg_addr     (reg_addr),
  .reg_rvalid   (reg_rvalid),
  .tx_in_ready  (tx_in_ready),
  .tx_out_valid (tx_out_valid),
  .tx_out_ready (tx_out_ready),
  .tx_out_byte  (tx_out_byte),
  .lcv_cnt      (lcv_cnt)
);

// File: tb/test_ctl_word_table.sv
module test_ctl_word_table;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 0, rx_lcv = 0;
  logic       rx_ready;
  logic [7:0] rx_idx = 0, rx_byte = 0;
  logic [2:0] rx_sync = 0;
  logic       tx_in_valid = 0, tx_in_ready, tx_out_valid, tx_out_ready = 1;
  logic [7:0] tx_in_idx = 0, tx_in_byte = 0, tx_out_byte;
  logic       reg_wr = 0, reg_rd = 0, reg_rvalid;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;

  ctl_word_table i_ctl_word_table (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  string cur_req = "R9";
  bit done = 0;
  bit stall_mode = 0;
  int cyc = 0;

  logic [7:0] m_rx [256];
  logic [7:0] m_tx [256];
  logic       m_en [256];
  logic [7:0] m_idx = 0;
  int         m_cnt = 0;
  logic       m_ov = 0, m_rv = 0, last_acc = 0;
  logic [7:0] m_ob = 0, m_rd = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    logic acc;
    acc = tx_in_valid && (!m_ov || tx_out_ready);
    last_acc = acc;
    m_rv = reg_rd;
    if (reg_rd) begin
      case (reg_addr)
        3'd0: m_rd = m_idx;
        3'd1: m_rd = m_rx[m_idx];
        3'd2: m_rd = m_tx[m_idx];
        3'd3: m_rd = {7'd0, m_en[m_idx]};
        3'd4: m_rd = 8'(m_cnt);
        default: m_rd = 8'd0;
      endcase
    end
    if (acc) begin
      m_ob = m_en[tx_in_idx] ? m_tx[tx_in_idx] : tx_in_byte;
      m_ov = 1;
    end else if (tx_out_ready) m_ov = 0;
    if (reg_wr) begin
      case (reg_addr)
        3'd0: m_idx = reg_wdata;
        3'd2: m_tx[m_idx] = reg_wdata;
        3'd3: m_en[m_idx] = reg_wdata[0];
        default: ;
      endcase
    end
    if (rx_valid && rx_sync == 3'd4) m_rx[rx_idx] = rx_byte;
    if (reg_wr && reg_addr == 3'd4) m_cnt = 0;
    else if (rx_valid && rx_lcv && m_cnt < 255) m_cnt++;
  endtask

  task automatic compare();
    check("R10 rx_ready", int'(rx_ready), 1);
    check({cur_req, " R7 tx_out_valid"}, int'(tx_out_valid), int'(m_ov));
    if (m_ov) check({cur_req, " tx_out_byte"}, int'(tx_out_byte), int'(m_ob));
    check("R7 tx_in_ready", int'(tx_in_ready), int'(!m_ov || tx_out_ready));
    check("R3 reg_rvalid", int'(reg_rvalid), int'(m_rv));
    if (m_rv) check({cur_req, " R3 reg_rdata"}, int'(reg_rdata), int'(m_rd));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    cyc++;
    if (stall_mode) tx_out_ready = cyc[1];
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 0;
  endtask

  task automatic reg_read(input logic [2:0] a, input logic [7:0] exp, input string req);
    reg_rd = 1; reg_addr = a;
    step();
    reg_rd = 0;
    check({req, " readback"}, int'(reg_rdata), int'(exp));
  endtask

  task automatic rx_put(input logic [7:0] i, input logic [7:0] b, input logic [2:0] s, input logic lcv);
    rx_valid = 1; rx_idx = i; rx_byte = b; rx_sync = s; rx_lcv = lcv;
    step();
    rx_valid = 0; rx_lcv = 0;
  endtask

  task automatic tx_send(input logic [7:0] i, input logic [7:0] b);
    tx_in_valid = 1; tx_in_idx = i; tx_in_byte = b;
    do step(); while (!last_acc);
    tx_in_valid = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin m_rx[i] = 0; m_tx[i] = 0; m_en[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9: reset state
    check("R9 tx_out_valid", int'(tx_out_valid), 0);
    check("R9 reg_rvalid", int'(reg_rvalid), 0);
    cur_req = "R9";
    reg_read(3'd0, 8'h00, "R9");
    reg_read(3'd1, 8'h00, "R9");
    reg_read(3'd3, 8'h00, "R9");
    reg_read(3'd4, 8'h00, "R9");

    // R1: capture under lock
    cur_req = "R1";
    rx_put(8'd0, 8'hA5, 3'd4, 0);
    rx_put(8'd7, 8'h3C, 3'd4, 0);
    rx_put(8'd255, 8'hE1, 3'd4, 0);
    reg_write(3'd0, 8'd7);
    reg_read(3'd1, 8'h3C, "R1");
    reg_write(3'd0, 8'd255);
    reg_read(3'd1, 8'hE1, "R1");
    reg_write(3'd0, 8'd0);
    reg_read(3'd1, 8'hA5, "R1");

    // R2: no capture without lock or without valid
    cur_req = "R2";
    rx_put(8'd0, 8'h11, 3'd3, 0);
    rx_put(8'd0, 8'h22, 3'd0, 0);
    rx_put(8'd0, 8'h33, 3'd5, 0);
    rx_valid = 0; rx_idx = 0; rx_byte = 8'h44; rx_sync = 3'd4; step();
    reg_read(3'd1, 8'hA5, "R2");
    reg_write(3'd0, 8'd7);
    reg_read(3'd1, 8'h3C, "R2");

    // R4: register map
    cur_req = "R4";
    reg_write(3'd0, 8'h5A);
    reg_read(3'd0, 8'h5A, "R4");
    reg_write(3'd2, 8'hC3);
    reg_read(3'd2, 8'hC3, "R4");
    reg_write(3'd3, 8'hFF);
    reg_read(3'd3, 8'h01, "R4");
    reg_write(3'd6, 8'h99);
    reg_read(3'd6, 8'h00, "R4");
    reg_read(3'd0, 8'h5A, "R4");

    // R3: read and write in the same cycle return the old value
    cur_req = "R3";
    reg_rd = 1; reg_wr = 1; reg_addr = 3'd2; reg_wdata = 8'h77;
    step();
    reg_rd = 0; reg_wr = 0;
    check("R3 old value on same-cycle write", int'(reg_rdata), 8'hC3);
    reg_read(3'd2, 8'h77, "R3");

    // R5: substitution at armed indices
    cur_req = "R5";
    reg_write(3'd0, 8'd3); reg_write(3'd2, 8'hB0); reg_write(3'd3, 8'h01);
    reg_write(3'd0, 8'd4); reg_write(3'd2, 8'hB4);
    for (int i = 0; i < 8; i++) tx_send(8'(i), 8'(8'h10 + i));
    tx_send(8'h5A, 8'h01);
    step(); step();

    // R6: same-cycle write and acceptance at one index
    cur_req = "R6";
    reg_write(3'd0, 8'd3);
    reg_wr = 1; reg_addr = 3'd2; reg_wdata = 8'hD6;
    tx_in_valid = 1; tx_in_idx = 8'd3; tx_in_byte = 8'h00;
    step();
    reg_wr = 0; tx_in_valid = 0;
    check("R6 old byte used", int'(tx_out_byte), 8'hB0);
    tx_send(8'd3, 8'h00);
    reg_wr = 1; reg_addr = 3'd3; reg_wdata = 8'h00;
    tx_in_valid = 1; tx_in_idx = 8'd3; tx_in_byte = 8'h9E;
    step();
    reg_wr = 0; tx_in_valid = 0;
    check("R6 old enable used", int'(tx_out_byte), 8'hD6);
    tx_send(8'd3, 8'h9E);
    step();

    // R7: back-pressure
    cur_req = "R7";
    stall_mode = 1;
    for (int i = 0; i < 12; i++) tx_send(8'(i % 6), 8'(8'h80 + i));
    stall_mode = 0; tx_out_ready = 1;
    step(); step();

    // R8: violation counter saturation and clear
    cur_req = "R8";
    for (int i = 0; i < 10; i++) rx_put(8'd1, 8'h00, 3'd1, 1);
    reg_read(3'd4, 8'd10, "R8");
    for (int i = 0; i < 260; i++) rx_put(8'd1, 8'h00, 3'd1, 1);
    reg_read(3'd4, 8'd255, "R8");
    rx_valid = 1; rx_lcv = 1; rx_sync = 3'd1;
    reg_write(3'd4, 8'h00);
    rx_valid = 0; rx_lcv = 0;
    reg_read(3'd4, 8'd0, "R8");
    rx_lcv = 1; step(); rx_lcv = 0;
    reg_read(3'd4, 8'd0, "R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired, run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule